// File: doc/BRIEF.md
# Interrupt Routing Indirect Register File

This block is the software-visible register front end of a 24-input interrupt routing controller. A bus master sees only two 32-bit locations in the mapped region: an index register and a data window. It writes an internal register number into the index register, then reads or writes that register through the window. Behind the window sit a read-only version word, a 4-bit controller identifier (reachable at two indices), and a routing table that holds one 64-bit entry per input. Software reaches each entry as two 32-bit halves.

The whole routing table is driven out in parallel to the delivery logic. The delivery logic is not part of this block. It flags, through `pend_set`, the entries whose level-style interrupt is awaiting acknowledgement. The register file tracks that flag in bit 14 of each entry. It also emits two one-cycle pulses. One reports any in-range rewrite of a table half. The other reports a write that flips an entry's mask bit, so downstream logic can react without scanning the table.

Top module: `irf_top`

## Requirements
- R1: A write at byte offset 0x00 keeps only bits 7:0 of the data in the index register. A read at offset 0x00 returns the index, zero-extended.
- R2: Window index 0x01 reads as {8'h00, PINS-1, 8'h00, VER_CODE}, with PINS-1 in bits 23:16 and VER_CODE in bits 7:0. Writes to it change nothing.
- R3: Window index 0x00 holds a 4-bit identifier written from, and read back in, bits 27:24. All other bits read zero. Index 0x02 reads the same value, and writes to 0x02 are ignored.
- R4: Window index 0x10+2n reaches bits 31:0 of table entry n, and index 0x11+2n reaches bits 63:32 of entry n. Entry n appears on `route_tbl[64n+63:64n]`.
- R5: A window index at or above 0x10 whose entry number is PINS or greater reads 0xFFFFFFFF. A write to it alters no entry and raises no pulse.
- R6: A write to the lower half of an entry forces its bit 14 (pending acknowledge) to 0, whatever the data holds in that bit. A write to the upper half leaves bit 14 unchanged.
- R7: `pend_set[n]` high at a clock edge sets bit 14 of entry n. If a lower-half write to entry n lands on the same edge, the set wins.
- R8: Synchronous reset leaves every entry at 64'h0000_0000_0001_0000 (mask bit 16 set), and clears the index register, the identifier and both pulses.
- R9: A write that changes bit 16 of an entry raises `mask_chg_vld` for one cycle after the write edge, with the entry number on `mask_chg_pin` and the new mask bit on `mask_chg_val`. A write that leaves the mask bit unchanged raises no mask pulse.
- R10: Every in-range table-half write raises `upd_vld` for one cycle after the write edge, with the entry number on `upd_pin`.
- R11: A bus write to any offset other than 0x00 and 0x10 changes nothing, and a read there returns 0. Window indices 0x03 to 0x0F read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the mapped region |
| bus_addr | input | ADDR_W | Byte offset within the region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pend_set | input | PINS | Per-entry request from delivery logic to set the pending-acknowledge bit |
| route_tbl | output | PINS*64 | All routing entries, entry n at bits 64n+63:64n |
| mask_chg_vld | output | 1 | One-cycle pulse: a write flipped an entry's mask bit |
| mask_chg_pin | output | PIN_W | Entry number for the mask pulse |
| mask_chg_val | output | 1 | New mask value for the mask pulse |
| upd_vld | output | 1 | One-cycle pulse: a table half was written |
| upd_pin | output | PIN_W | Entry number for the write pulse |

## Verification
Two actions can hit the same entry in one cycle: a software write to the lower half, which clears the pending-acknowledge bit, and a `pend_set` request from the delivery side, which sets it. The bench drives both on a single edge for the same entry and expects the bit to read 1 afterwards. It also drives a plain lower-half write with no request and expects the bit to read 0. Mask and write pulses are judged together on the cycle after each table write.

// File: rtl/irf_pkg.sv
package irf_pkg;
    localparam int DATA_W = 32;
    localparam int ENT_W = 64;
    localparam int IDX_W = 8;

    // bus offsets (byte addresses inside the mapped region)
    localparam logic [7:0] OFF_INDEX = 8'h00;
    localparam logic [7:0] OFF_DATA = 8'h10;

    // window indices
    localparam logic [IDX_W-1:0] IX_IDENT = 8'h00;
    localparam logic [IDX_W-1:0] IX_VERS = 8'h01;
    localparam logic [IDX_W-1:0] IX_ARBI = 8'h02;
    localparam logic [IDX_W-1:0] IX_TBL_BASE = 8'h10;

    // entry field positions
    localparam int BIT_PEND = 14;
    localparam int BIT_MASK = 16;
    localparam logic [ENT_W-1:0] ENT_RST = 64'h0000_0000_0001_0000;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_INDEX,
        TGT_DATA
    } bus_tgt_e;

    typedef struct packed {
        logic is_ident;
        logic is_vers;
        logic is_arbi;
        logic is_tbl;
        logic in_rng;
        logic hi_half;
        logic [IDX_W-2:0] ent_num;
    } win_dec_t;

    function automatic logic [IDX_W-2:0] tbl_entry(input logic [IDX_W-1:0] ix);
        logic [IDX_W-1:0] off;
        off = ix - IX_TBL_BASE;
        return off[IDX_W-1:1];
    endfunction
endpackage

// File: rtl/irf_bus_dec.sv
module irf_bus_dec
    import irf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_tgt_e          tgt
);
    localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(OFF_INDEX);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);

    always_comb begin
        if (addr == A_INDEX) tgt = TGT_INDEX;
        else if (addr == A_DATA) tgt = TGT_DATA;
        else tgt = TGT_NONE;
    end
endmodule

// File: rtl/irf_win_dec.sv
module irf_win_dec
    import irf_pkg::*;
#(
    parameter int PINS = 24
) (
    input  logic [IDX_W-1:0] ix,
    output win_dec_t         dec
);
    always_comb begin
        dec = '0;
        dec.is_ident = (ix == IX_IDENT);
        dec.is_vers = (ix == IX_VERS);
        dec.is_arbi = (ix == IX_ARBI);
        dec.is_tbl = (ix >= IX_TBL_BASE);
        dec.hi_half = ix[0];
        dec.ent_num = tbl_entry(ix);
        dec.in_rng = dec.is_tbl && (int'(dec.ent_num) < PINS);
    end
endmodule

// File: rtl/irf_entry.sv
module irf_entry
    import irf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pend_set,
    output logic [ENT_W-1:0]  ent
);
    logic [ENT_W-1:0] ent_nxt;

    always_comb begin
        ent_nxt = ent;
        if (wr_hi) ent_nxt[ENT_W-1:DATA_W] = wdata;
        if (wr_lo) begin
            ent_nxt[DATA_W-1:0] = wdata;
            ent_nxt[BIT_PEND] = 1'b0;
        end
        if (pend_set) ent_nxt[BIT_PEND] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ent <= ENT_RST;
        else ent <= ent_nxt;
    end
endmodule

// File: rtl/irf_top.sv
module irf_top
    import irf_pkg::*;
#(
    parameter int PINS = 24,
    parameter int ADDR_W = 8,
    parameter logic [7:0] VER_CODE = 8'h11,
    localparam int PIN_W = $clog2(PINS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [PINS-1:0]       pend_set,
    output logic [PINS*ENT_W-1:0] route_tbl,
    output logic                  mask_chg_vld,
    output logic [PIN_W-1:0]      mask_chg_pin,
    output logic                  mask_chg_val,
    output logic                  upd_vld,
    output logic [PIN_W-1:0]      upd_pin
);
    localparam logic [7:0] MAX_PIN = 8'(PINS - 1);
    localparam logic [DATA_W-1:0] VERS_WORD = {8'h00, MAX_PIN, 8'h00, VER_CODE};

    bus_tgt_e tgt;
    win_dec_t wdec;
    logic [IDX_W-1:0] sel_q;
    logic [3:0] ident_q;
    logic [PINS-1:0][ENT_W-1:0] ents;
    logic [PIN_W-1:0] wpin;
    logic wr_data, wr_tbl, mask_old;
    logic [DATA_W-1:0] win_rd;

    irf_bus_dec #(.ADDR_W(ADDR_W)) u_bdec (.addr(bus_addr), .tgt(tgt));
    irf_win_dec #(.PINS(PINS)) u_wdec (.ix(sel_q), .dec(wdec));

    assign wr_data = bus_wr && (tgt == TGT_DATA);
    assign wr_tbl = wr_data && wdec.in_rng;
    assign wpin = wdec.ent_num[PIN_W-1:0];

    for (genvar g = 0; g < PINS; g++) begin : g_ent
        logic hit;
        assign hit = wr_tbl && (int'(wpin) == g);
        irf_entry u_ent (
            .clk(clk),
            .rst(rst),
            .wr_lo(hit && !wdec.hi_half),
            .wr_hi(hit && wdec.hi_half),
            .wdata(bus_wdata),
            .pend_set(pend_set[g]),
            .ent(ents[g])
        );
    end

    assign route_tbl = ents;
    assign mask_old = ents[wpin][BIT_MASK];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            ident_q <= '0;
            mask_chg_vld <= 1'b0;
            mask_chg_pin <= '0;
            mask_chg_val <= 1'b0;
            upd_vld <= 1'b0;
            upd_pin <= '0;
        end else begin
            if (bus_wr && tgt == TGT_INDEX) sel_q <= bus_wdata[IDX_W-1:0];
            if (wr_data && wdec.is_ident) ident_q <= bus_wdata[27:24];
            upd_vld <= wr_tbl;
            upd_pin <= wpin;
            mask_chg_vld <= wr_tbl && !wdec.hi_half && (bus_wdata[BIT_MASK] != mask_old);
            mask_chg_pin <= wpin;
            mask_chg_val <= bus_wdata[BIT_MASK];
        end
    end

    always_comb begin
        win_rd = '0;
        if (wdec.is_tbl) begin
            if (!wdec.in_rng) win_rd = '1;
            else if (wdec.hi_half) win_rd = ents[wpin][ENT_W-1:DATA_W];
            else win_rd = ents[wpin][DATA_W-1:0];
        end else if (wdec.is_ident || wdec.is_arbi) begin
            win_rd = {4'h0, ident_q, 24'h0};
        end else if (wdec.is_vers) begin
            win_rd = VERS_WORD;
        end
    end

    always_comb begin
        case (tgt)
            TGT_INDEX: bus_rdata = {{(DATA_W-IDX_W){1'b0}}, sel_q};
            TGT_DATA:  bus_rdata = win_rd;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irf_chk.sv
module irf_chk
    import irf_pkg::*;
#(
    parameter int PINS = 24,
    parameter int ADDR_W = 8,
    localparam int PIN_W = $clog2(PINS)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [IDX_W-1:0]      sel_q,
    input logic [PINS-1:0]       pend_set,
    input logic [PINS*ENT_W-1:0] route_tbl,
    input logic                  mask_chg_vld,
    input logic [PIN_W-1:0]      mask_chg_pin,
    input logic                  mask_chg_val,
    input logic                  upd_vld,
    input logic [PIN_W-1:0]      upd_pin
);
    logic [PINS-1:0][ENT_W-1:0] tv;
    logic win_wr, idx_wr, tbl_ix, oor;
    logic [IDX_W-2:0] enum_c;
    logic [PIN_W-1:0] epin;

    assign tv = route_tbl;
    assign win_wr = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
    assign idx_wr = bus_wr && (bus_addr == ADDR_W'(OFF_INDEX));
    assign tbl_ix = sel_q >= IX_TBL_BASE;
    assign enum_c = (IDX_W-1)'((sel_q - IX_TBL_BASE) >> 1);
    assign oor = tbl_ix && (int'(enum_c) >= PINS);
    assign epin = enum_c[PIN_W-1:0];

    AST_SEL_KEEP_LOW8: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> sel_q == $past(bus_wdata[7:0])); // R1

    AST_MASK_PULSE_STATE: assert property (@(posedge clk) disable iff (rst)
        mask_chg_vld |-> tv[mask_chg_pin][BIT_MASK] == mask_chg_val); // R9

    AST_MASK_WITH_UPD: assert property (@(posedge clk) disable iff (rst)
        mask_chg_vld |-> upd_vld && upd_pin == mask_chg_pin); // R10

    AST_OOR_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (win_wr && oor && pend_set == '0) |=> $stable(route_tbl) && !upd_vld); // R5

    AST_LO_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        (win_wr && tbl_ix && !oor && !sel_q[0] && !pend_set[epin])
        |=> tv[$past(epin)][BIT_PEND] == 1'b0); // R6

    for (genvar k = 0; k < PINS; k++) begin : g_pend
        AST_PEND_SETS: assert property (@(posedge clk) disable iff (rst)
            pend_set[k] |=> tv[k][BIT_PEND]); // R7
    end
endmodule

bind irf_top irf_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk),
    .rst(rst),
    .bus_wr(bus_wr),
    .bus_addr(bus_addr),
    .bus_wdata(bus_wdata),
    .sel_q(sel_q),
    .pend_set(pend_set),
    .route_tbl(route_tbl),
    .mask_chg_vld(mask_chg_vld),
    .mask_chg_pin(mask_chg_pin),
    .mask_chg_val(mask_chg_val),
    .upd_vld(upd_vld),
    .upd_pin(upd_pin)
);

// File: tb/sim_irf_top.sv
module sim_irf_top;
    localparam int CLK_PERIOD = 10;
    localparam int PINS = 24;
    localparam int PIN_W = $clog2(PINS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [PINS-1:0] pend_set = '0;
    logic [PINS*64-1:0] route_tbl;
    logic mask_chg_vld, mask_chg_val, upd_vld;
    logic [PIN_W-1:0] mask_chg_pin, upd_pin;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irf_top #(.PINS(PINS)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_set(pend_set),
        .route_tbl(route_tbl), .mask_chg_vld(mask_chg_vld),
        .mask_chg_pin(mask_chg_pin), .mask_chg_val(mask_chg_val),
        .upd_vld(upd_vld), .upd_pin(upd_pin)
    );

    // {index, data written through window, expected readback}
    localparam logic [71:0] VEC [10] = '{
        {8'h10, 32'h0001_00A5, 32'h0001_00A5},  // R4 entry 0 low
        {8'h11, 32'hFF00_0000, 32'hFF00_0000},  // R4 entry 0 high
        {8'h12, 32'h0000_4033, 32'h0000_0033},  // R6 bit 14 dropped
        {8'h3F, 32'h1234_5678, 32'h1234_5678},  // R4 last entry high
        {8'h3E, 32'h0001_0000, 32'h0001_0000},  // R4 last entry low
        {8'h40, 32'h0000_DEAD, 32'hFFFF_FFFF},  // R5 out of range
        {8'h01, 32'h0000_0000, 32'h0017_0011},  // R2 version read-only
        {8'h00, 32'hA500_0000, 32'h0500_0000},  // R3 identifier
        {8'h02, 32'h0000_0000, 32'h0500_0000},  // R3 arbitration alias
        {8'h05, 32'h0000_0001, 32'h0000_0000}   // R11 unused index
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [63:0] ent(input int n);
        return route_tbl[64*n +: 64];
    endfunction

    initial begin
        logic [31:0] rv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        bus_read(8'h00, rv);
        check("R8 index after reset", 64'(rv), 64'h0);
        for (int i = 0; i < PINS; i++) check("R8 entry reset", ent(i), 64'h0000_0000_0001_0000);
        check("R8 pulses idle", {62'h0, mask_chg_vld, upd_vld}, 64'h0);
        bus_write(8'h00, 32'h0000_0000);
        bus_read(8'h10, rv);
        check("R8 identifier reset", 64'(rv), 64'h0);

        // R1 index keeps low byte
        bus_write(8'h00, 32'h0000_0ABC);
        bus_read(8'h00, rv);
        check("R1 index low 8 bits", 64'(rv), 64'h0000_00BC);

        // table walk
        foreach (VEC[v]) begin
            bus_write(8'h00, {24'h0, VEC[v][71:64]});
            bus_write(8'h10, VEC[v][63:32]);
            bus_read(8'h10, rv);
            check("R2/R3/R4/R5/R6/R11 vector readback", 64'(rv), 64'(VEC[v][31:0]));
        end
        check("R4 entry 23 on route_tbl", ent(23), 64'h1234_5678_0001_0000);
        check("R4 entry 0 on route_tbl", ent(0), 64'hFF00_0000_0001_00A5);

        // R5 out-of-range write gives no pulse and no change
        bus_write(8'h00, 32'h0000_0040);
        bus_write(8'h10, 32'h0000_0000);
        check("R5 no pulse out of range", {63'h0, upd_vld}, 64'h0);
        check("R5 entry 23 untouched", ent(23), 64'h1234_5678_0001_0000);

        // R9 / R10 mask flip on entry 3
        bus_write(8'h00, 32'h0000_0016);
        bus_write(8'h10, 32'h0000_0040);
        check("R9 mask pulse", {62'h0, mask_chg_vld, mask_chg_val}, 64'h2);
        check("R9 mask pulse pin", 64'(mask_chg_pin), 64'd3);
        check("R10 write pulse", {58'h0, upd_vld, PIN_W'(upd_pin)}, {58'h0, 1'b1, 5'd3});
        @(negedge clk);
        check("R9 pulse lasts one cycle", {62'h0, mask_chg_vld, upd_vld}, 64'h0);
        bus_write(8'h10, 32'h0000_0041);
        check("R9 no pulse when mask unchanged", {63'h0, mask_chg_vld}, 64'h0);
        check("R10 pulse on every write", {63'h0, upd_vld}, 64'h1);
        bus_write(8'h10, 32'h0001_0041);
        check("R9 mask set again", {62'h0, mask_chg_vld, mask_chg_val}, 64'h3);

        // R7 / R6 pending bit on entry 5
        @(negedge clk);
        pend_set = 24'(1) << 5;
        @(negedge clk);
        pend_set = '0;
        check("R7 pend set", 64'(ent(5)[14]), 64'h1);
        bus_write(8'h00, 32'h0000_001B);
        bus_write(8'h10, 32'hAA00_0000);
        check("R6 upper write keeps pend", 64'(ent(5)[14]), 64'h1);
        bus_write(8'h00, 32'h0000_001A);
        bus_write(8'h10, 32'h0001_4000);
        check("R6 lower write clears pend", ent(5), 64'hAA00_0000_0001_0000);

        // R7 same-cycle set and lower write on entry 6
        bus_write(8'h00, 32'h0000_001C);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = 8'h10;
        bus_wdata = 32'h0001_0022;
        pend_set = 24'(1) << 6;
        @(negedge clk);
        bus_wr = 1'b0;
        pend_set = '0;
        check("R7 set wins over lower write", ent(6), 64'h0000_0000_0001_4022);

        // R11 other offsets
        bus_write(8'h20, 32'h0000_0012);
        bus_read(8'h00, rv);
        check("R11 stray offset write ignored", 64'(rv), 64'h1C);
        bus_read(8'h20, rv);
        check("R11 stray offset reads zero", 64'(rv), 64'h0);
        bus_read(8'h04, rv);
        check("R11 offset 0x04 reads zero", 64'(rv), 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule